// File: doc/BRIEF.md
# Auto-Indexing Pointer Register with Write-Back Forwarding

This block is one 32-bit pointer register of a small pipelined processor core. The register file of the core gives it one register address, and it sees every ALU write-back. An ALU write-back that targets that address loads all 32 bits. An auto-step request moves only the low 20-bit address field up or down by a small signed amount. This indexed address field is always visible to the memory stage.

Operand read ports (source and destination) return the stored value. There is one exception. When the ALU is writing this register in the same cycle that a port reads it, the port returns the raw ALU result, bypassing the register. That forwarded value is never trimmed, because the path is timing-critical. A parameter selects a legacy narrow variant, in which only the 20-bit field is kept and the upper 12 bits read back as zero. In that variant a forwarded read can still show nonzero upper bits.

Top module: `ptr_index_reg`

## Requirements
- R1: While reset is applied and after it is released, every read port that selects the pointer returns 0 and the address field output is 0.
- R2: An auto-step adds the signed two's-complement step (6 bits by default, range -32..+31, used for -16..+16) to bits 19..0, modulo 2^20; any carry or borrow out of bit 19 is discarded.
- R3: An auto-step leaves bits 31..20 unchanged.
- R4: An ALU write whose address equals the pointer's address loads all 32 bits at the next clock edge. A write to any other address leaves the pointer unchanged.
- R5: When an ALU write to the pointer and an auto-step fall in the same cycle, the written value is stored and the step is dropped.
- R6: A read port whose address equals the pointer's address returns the stored value. If in that same cycle an ALU write to the pointer is active, the port instead returns the full, unmasked ALU value. Auto-steps are never forwarded.
- R7: The two read ports (port 0 in the low bits of the packed buses, port 1 in the high bits) select and forward independently of each other.
- R8: With the legacy narrow parameter set, stored reads return zero in bits 31..20, but a forwarded read still returns all 32 bits of the ALU value.
- R9: A read port whose address does not select the pointer returns 0, even when a write to that other address is active.
- R10: With neither a write to the pointer nor a step, the stored value holds.
- R11: The address field output always equals bits 19..0 of the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_n_i | input | 1 | Active-low reset, asserted asynchronously, released on the clock |
| wr_en_i | input | 1 | ALU write-back valid |
| wr_addr_i | input | 9 | ALU write-back register address |
| wr_data_i | input | 32 | ALU write-back result |
| step_en_i | input | 1 | Auto-step request |
| step_i | input | 6 | Signed step amount |
| rd_addr_i | input | 18 | Read addresses, port 0 in bits 8..0, port 1 in bits 17..9 |
| rd_data_o | output | 64 | Read data, port 0 in bits 31..0, port 1 in bits 63..32 |
| field_o | output | 20 | Stored address field for memory indexing |

## Verification
Any corrupted stored bit appears on a selected read port and, for bits 19..0, on `field_o` in the very next cycle. Nothing inside hides state from the ports. A broken forwarding select shows up only in the cycle of the write itself, so every write scenario samples the read ports during that cycle and again one cycle later. A carry that leaks past bit 19, or a step that wins over a write, shows up as a wrong upper or low field one cycle after the step. The bench drives steps across both field boundaries to catch this. The narrow variant is run alongside the wide one, so the difference between forwarded and stored upper bits is compared in the same cycles.

// File: rtl/ptr_idx_pkg.sv
package ptr_idx_pkg;

  // Operation applied to the stored pointer at the next edge
  typedef enum logic [1:0] {
    PTR_OP_HOLD = 2'd0,
    PTR_OP_LOAD = 2'd1,
    PTR_OP_STEP = 2'd2
  } ptr_op_e;

endpackage

// File: rtl/ptr_rst_sync.sv
module ptr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_async_i,
  output logic rst_n_sync_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_async_i) begin
    if (!rst_n_async_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync_o = sync_q[STAGES-1];

endmodule

// File: rtl/ptr_step_unit.sv
module ptr_step_unit #(
  parameter int unsigned FIELD_W = 20,
  parameter int unsigned STEP_W  = 6
) (
  input  logic [FIELD_W-1:0]       field_i,
  input  logic signed [STEP_W-1:0] step_i,
  output logic [FIELD_W-1:0]       field_o
);

  localparam int unsigned EXT_W = FIELD_W - STEP_W;

  logic [FIELD_W-1:0] step_ext;

  // Sign-extend to field width; the sum wraps inside the field
  always_comb begin
    step_ext = {{EXT_W{step_i[STEP_W-1]}}, step_i};
    field_o  = field_i + step_ext;
  end

endmodule

// File: rtl/ptr_store.sv
module ptr_store
  import ptr_idx_pkg::*;
#(
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned FIELD_W       = 20,
  parameter bit          LEGACY_NARROW = 1'b0
) (
  input  logic                      clk_i,
  input  logic                      rst_n_i,
  input  ptr_op_e                   op_i,
  input  logic [DATA_W-1:0]         load_data_i,
  input  logic [FIELD_W-1:0]        step_field_i,
  output logic [FIELD_W-1:0]        field_q_o,
  output logic [DATA_W-FIELD_W-1:0] upper_q_o
);

  localparam int unsigned UPPER_W = DATA_W - FIELD_W;

  logic               field_en;
  logic [FIELD_W-1:0] field_d;
  logic [FIELD_W-1:0] field_q;

  // Low field: loaded by ALU, moved by step
  always_comb begin
    field_en = (op_i != PTR_OP_HOLD);
    field_d  = (op_i == PTR_OP_LOAD) ? load_data_i[FIELD_W-1:0] : step_field_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      field_q <= '0;
    end else if (field_en) begin
      field_q <= field_d;
    end
  end

  assign field_q_o = field_q;

  // Upper bits: plain storage, only an ALU load touches them
  generate
    if (LEGACY_NARROW) begin : g_narrow
      assign upper_q_o = '0;
    end else begin : g_wide
      logic               upper_en;
      logic [UPPER_W-1:0] upper_d;
      logic [UPPER_W-1:0] upper_q;

      always_comb begin
        upper_en = (op_i == PTR_OP_LOAD);
        upper_d  = load_data_i[DATA_W-1:FIELD_W];
      end

      always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
          upper_q <= '0;
        end else if (upper_en) begin
          upper_q <= upper_d;
        end
      end

      assign upper_q_o = upper_q;

      AST_STEP_UPPER_KEPT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (op_i == PTR_OP_STEP) |=> (upper_q_o == $past(upper_q_o))); // R3

      AST_LOAD_UPPER: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (op_i == PTR_OP_LOAD) |=> (upper_q_o == $past(load_data_i[DATA_W-1:FIELD_W]))); // R4
    end
  endgenerate

  AST_LOAD_FIELD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (op_i == PTR_OP_LOAD) |=> (field_q_o == $past(load_data_i[FIELD_W-1:0]))); // R4

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (op_i == PTR_OP_HOLD) |=> ($stable(field_q_o) && $stable(upper_q_o))); // R10

endmodule

// File: rtl/ptr_rd_port.sv
module ptr_rd_port #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 9,
  parameter logic [ADDR_W-1:0] PTR_ADDR = '0
) (
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] stored_i,
  output logic [DATA_W-1:0] rd_data_o
);

  logic sel;
  logic fwd_hit;

  // Forward the raw ALU value; no masking on this path
  always_comb begin
    sel     = (rd_addr_i == PTR_ADDR);
    fwd_hit = sel && wr_en_i && (wr_addr_i == rd_addr_i);
    if (!sel) begin
      rd_data_o = '0;
    end else if (fwd_hit) begin
      rd_data_o = wr_data_i;
    end else begin
      rd_data_o = stored_i;
    end
  end

endmodule

// File: rtl/ptr_index_reg.sv
module ptr_index_reg
  import ptr_idx_pkg::*;
#(
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned FIELD_W       = 20,
  parameter int unsigned STEP_W        = 6,
  parameter int unsigned ADDR_W        = 9,
  parameter int unsigned NUM_RD        = 2,
  parameter logic [ADDR_W-1:0] PTR_ADDR = 9'h1F8,
  parameter bit          LEGACY_NARROW = 1'b0
) (
  input  logic                     clk_i,
  input  logic                     rst_n_i,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic                     step_en_i,
  input  logic signed [STEP_W-1:0] step_i,
  input  logic [NUM_RD*ADDR_W-1:0] rd_addr_i,
  output logic [NUM_RD*DATA_W-1:0] rd_data_o,
  output logic [FIELD_W-1:0]       field_o
);

  localparam int unsigned UPPER_W = DATA_W - FIELD_W;

  logic               rst_n;
  ptr_op_e            op;
  logic               load_hit;
  logic [FIELD_W-1:0] field_q;
  logic [UPPER_W-1:0] upper_q;
  logic [FIELD_W-1:0] field_stepped;
  logic [DATA_W-1:0]  stored;

  ptr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i         (clk_i),
    .rst_n_async_i (rst_n_i),
    .rst_n_sync_o  (rst_n)
  );

  // ALU write wins over a step in the same cycle
  always_comb begin
    load_hit = wr_en_i && (wr_addr_i == PTR_ADDR);
    if (load_hit) begin
      op = PTR_OP_LOAD;
    end else if (step_en_i) begin
      op = PTR_OP_STEP;
    end else begin
      op = PTR_OP_HOLD;
    end
  end

  ptr_step_unit #(.FIELD_W(FIELD_W), .STEP_W(STEP_W)) u_step (
    .field_i (field_q),
    .step_i  (step_i),
    .field_o (field_stepped)
  );

  ptr_store #(
    .DATA_W        (DATA_W),
    .FIELD_W       (FIELD_W),
    .LEGACY_NARROW (LEGACY_NARROW)
  ) u_store (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n),
    .op_i         (op),
    .load_data_i  (wr_data_i),
    .step_field_i (field_stepped),
    .field_q_o    (field_q),
    .upper_q_o    (upper_q)
  );

  assign stored  = {upper_q, field_q};
  assign field_o = field_q;

  generate
    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      ptr_rd_port #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .PTR_ADDR (PTR_ADDR)
      ) u_port (
        .rd_addr_i (rd_addr_i[p*ADDR_W +: ADDR_W]),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .stored_i  (stored),
        .rd_data_o (rd_data_o[p*DATA_W +: DATA_W])
      );

      // A forwarded low field must match what lands in storage
      AST_FWD_MATCHES_STORE: assert property (@(posedge clk_i) disable iff (!rst_n)
        (wr_en_i && (wr_addr_i == PTR_ADDR) && (rd_addr_i[p*ADDR_W +: ADDR_W] == PTR_ADDR))
        |=> (field_o == $past(rd_data_o[p*DATA_W +: FIELD_W]))); // R6
    end
  endgenerate

  // Checker-only: expected field after a step
  logic [FIELD_W-1:0] chk_step_ext;
  assign chk_step_ext = {{(FIELD_W-STEP_W){step_i[STEP_W-1]}}, step_i};

  AST_STEP_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (step_en_i && !load_hit) |=> (field_o == $past(field_o + chk_step_ext))); // R2

  AST_WRITE_BEATS_STEP: assert property (@(posedge clk_i) disable iff (!rst_n)
    (step_en_i && load_hit) |=> (field_o == $past(wr_data_i[FIELD_W-1:0]))); // R5

endmodule

// File: tb/ptr_index_reg_tb.sv
`timescale 1ns/1ps
module ptr_index_reg_tb_top;

  localparam logic [8:0] PTR   = 9'h1F8;
  localparam logic [8:0] OTHER = 9'h1F9;

  logic               clk_i = 1'b0;
  logic               rst_n_i;
  logic               wr_en;
  logic [8:0]         wr_addr;
  logic [31:0]        wr_data;
  logic               step_en;
  logic signed [5:0]  step;
  logic [17:0]        rd_addr;
  logic [63:0]        rdw;
  logic [63:0]        rdn;
  logic [19:0]        fw;
  logic [19:0]        fn;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  ptr_index_reg #(.PTR_ADDR(PTR), .LEGACY_NARROW(1'b0)) dut_i (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .step_en_i(step_en), .step_i(step),
    .rd_addr_i(rd_addr), .rd_data_o(rdw), .field_o(fw));

  ptr_index_reg #(.PTR_ADDR(PTR), .LEGACY_NARROW(1'b1)) dut_leg_i (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .step_en_i(step_en), .step_i(step),
    .rd_addr_i(rd_addr), .rd_data_o(rdn), .field_o(fn));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 1'b0; wr_addr = OTHER; wr_data = '0;
    step_en = 1'b0; step = '0;
    rd_addr = {PTR, PTR};
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
    idle();
    #1;
  endtask

  // Stored values of both variants, read with no write active
  task automatic chk_stored(input string tag, input logic [31:0] exp_w);
    chk({tag, " wide p0"}, rdw[31:0], exp_w);
    chk({tag, " wide p1"}, rdw[63:32], exp_w);
    chk({tag, " narrow p0"}, rdn[31:0], {12'h000, exp_w[19:0]});
    chk({tag, " field"}, {12'h000, fw}, {12'h000, exp_w[19:0]});
  endtask

  task automatic load(input logic [31:0] d);
    @(negedge clk_i);
    wr_en = 1'b1; wr_addr = PTR; wr_data = d;
    tick();
  endtask

  task automatic do_step(input logic signed [5:0] s);
    @(negedge clk_i);
    step_en = 1'b1; step = s;
    tick();
  endtask

  task automatic t_reset();
    rst_n_i = 1'b0;
    idle();
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 in reset wide", rdw[31:0], 32'h0);
    chk("R1 in reset narrow", rdn[31:0], 32'h0);
    @(negedge clk_i);
    rst_n_i = 1'b1;
    repeat (4) @(posedge clk_i);
    #1;
    chk_stored("R1 after reset", 32'h0);
  endtask

  task automatic t_load_fwd();
    @(negedge clk_i);
    wr_en = 1'b1; wr_addr = PTR; wr_data = 32'hF100_0000;
    #1;
    chk("R6 forward wide", rdw[31:0], 32'hF100_0000);
    chk("R8 forward narrow unmasked", rdn[31:0], 32'hF100_0000);
    chk("R7 forward port1", rdn[63:32], 32'hF100_0000);
    tick();
    chk("R4 load wide", rdw[31:0], 32'hF100_0000);
    chk("R8 narrow stored upper zero", rdn[31:0], 32'h0000_0000);
    // write to another register: no effect, not forwarded
    @(negedge clk_i);
    wr_en = 1'b1; wr_addr = OTHER; wr_data = 32'h1234_5678;
    rd_addr = {OTHER, PTR};
    #1;
    chk("R9 other addr reads zero", rdw[63:32], 32'h0);
    chk("R6 no hit reads stored", rdw[31:0], 32'hF100_0000);
    tick();
    chk("R4 other write ignored", rdw[31:0], 32'hF100_0000);
  endtask

  task automatic t_step();
    load(32'hABCF_FFFE);
    chk_stored("R4 load", 32'hABCF_FFFE);
    @(negedge clk_i);
    step_en = 1'b1; step = 6'sd2;
    #1;
    chk("R6 step not forwarded", rdw[31:0], 32'hABCF_FFFE);
    tick();
    chk_stored("R2 R3 carry dropped", 32'hABC0_0000);
    do_step(-6'sd1);
    chk_stored("R2 R3 borrow dropped", 32'hABCF_FFFF);
    do_step(6'sd16);
    chk_stored("R2 step +16", 32'hABC0_000F);
    do_step(-6'sd16);
    chk_stored("R2 step -16", 32'hABCF_FFFF);
  endtask

  task automatic t_prio();
    @(negedge clk_i);
    wr_en = 1'b1; wr_addr = PTR; wr_data = 32'h5550_0010;
    step_en = 1'b1; step = 6'sd5;
    tick();
    chk_stored("R5 write beats step", 32'h5550_0010);
  endtask

  task automatic t_hold();
    repeat (5) @(posedge clk_i);
    #1;
    chk_stored("R10 hold", 32'h5550_0010);
    chk("R11 field narrow", {12'h000, fn}, 32'h0000_0010);
  endtask

  task automatic t_ports();
    @(negedge clk_i);
    wr_en = 1'b1; wr_addr = PTR; wr_data = 32'hC0DE_0042;
    rd_addr = {PTR, OTHER};
    #1;
    chk("R7 port0 unselected", rdw[31:0], 32'h0);
    chk("R7 port1 forwards", rdw[63:32], 32'hC0DE_0042);
    tick();
    chk_stored("R7 after write", 32'hC0DE_0042);
  endtask

  initial begin
    t_reset();
    t_load_fwd();
    t_step();
    t_prio();
    t_hold();
    t_ports();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #40000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule